// File: doc/BRIEF.md
# SPI Control Register Access Target

This block is the command engine that sits behind a word-oriented SPI slave shifter on the device side of a serial host link. The shifter presents each complete 32-bit word received from the host with a one-cycle strobe. It also transmits whatever word the engine holds in its response register during the next word slot. The engine decodes a control header from the first word of a select window. It then walks a run of consecutive register addresses, either returning their contents or committing host data to them.

Registers are reached through a plain register-file port. The engine drives an address, and a combinational decode answers with read data and a hit flag that says whether the address exists. Absent addresses read as zero, and writes to them are dropped. A write command echoes its header and every data word back to the host one word late, so the host can tell which write went wrong when the bus is disturbed. Dropping the select at any point abandons the command.

Top module: `spi_ctl_target`

## Requirements
- R1: The first word after select rises is the header. Bit 31 set means write and clear means read. Bits [ADDR_W+CNT_W-1:CNT_W] hold the start address A. Bits [CNT_W-1:0] hold N-1, where N is the number of registers, so a field of zero means one register.
- R2: In a read, the response word during the k-th word slot after the header (k = 1..N) is the content of register (A+k-1) modulo 2^ADDR_W.
- R3: In a read, host words after the header are ignored, and the register write strobe never rises.
- R4: A read of an address whose hit flag is low returns zero in place of the register data.
- R5: In a write, the k-th data word after the header (k = 1..N) is committed to register (A+k-1) modulo 2^ADDR_W.
- R6: In a write, the response during data slot 1 is the header, and the response during slot k+1 is data word k. The response during the trailing slot is data word N.
- R7: The word that follows the N data words of a write is ignored and commits nothing.
- R8: A write aimed at an address whose hit flag is low raises no write strobe.
- R9: Select going low aborts any command at the next edge. The engine returns to header wait and the response word becomes zero.
- R10: Once a command is complete, further words in the same select window are ignored and answered with zero.
- R11: After reset the response word is zero, no write strobe is raised, and the engine waits for a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 1 | Select window active (framed by the shifter) |
| w_vld | input | 1 | One-cycle strobe: a host word is complete |
| w_data | input | 32 | Host word received |
| miso_word | output | 32 | Response word sent during the next word slot |
| reg_addr | output | ADDR_W | Register-file address |
| reg_rdata | input | 32 | Register-file read data (combinational) |
| reg_hit | input | 1 | Address is implemented |
| reg_we | output | 1 | Register write strobe |
| reg_wdata | output | 32 | Register write data |

## Verification
A wrong address counter or remaining-count register shows up as a shifted or wrong word at the port. In a read, the wrong register content appears in the very next response slot. In a write, the register file is changed at the wrong location on the same strobe. A sequencer stuck in the wrong phase is seen at the latest one word later. It shows as a missing echo, or as a write strobe during a read, a trailing slot or an abort. A missed abort leaves a nonzero response in the first slot of the next window.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] ctl_word_t;
  typedef enum logic [2:0] {
    ST_HDR,
    ST_RD,
    ST_WR,
    ST_TRAIL,
    ST_DONE
  } ctl_state_e;
endpackage

// File: rtl/ctl_seq.sv
module ctl_seq
  import ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       w_vld,
  input  logic       hdr_wr,
  input  logic       last,
  output ctl_state_e state,
  output logic       ev_hdr,
  output logic       ev_rd,
  output logic       ev_wr,
  output logic       ev_trail
);
  logic       take;
  ctl_state_e nxt;

  assign take     = sel & w_vld;
  assign ev_hdr   = take && (state == ST_HDR);
  assign ev_rd    = take && (state == ST_RD);
  assign ev_wr    = take && (state == ST_WR);
  assign ev_trail = take && (state == ST_TRAIL);

  always_comb begin
    nxt = state;
    if (!sel) begin
      nxt = ST_HDR;
    end else if (w_vld) begin
      unique case (state)
        ST_HDR:   nxt = hdr_wr ? ST_WR : ST_RD;
        ST_RD:    nxt = last ? ST_DONE : ST_RD;
        ST_WR:    nxt = last ? ST_TRAIL : ST_WR;
        ST_TRAIL: nxt = ST_DONE;
        default:  nxt = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_HDR;
    else        state <= nxt;
  end

  AST_ABORT_TO_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (state == ST_HDR)); // R9
  AST_TRAIL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trail |=> (state == ST_DONE) || !sel); // R7
endmodule

// File: rtl/ctl_addr_gen.sv
module ctl_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              step,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last
);
  logic [CNT_W-1:0] left;

  assign last = (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      left     <= '0;
    end else if (load) begin
      cur_addr <= load_addr;
      left     <= load_cnt;
    end else if (step) begin
      cur_addr <= cur_addr + 1'b1;
      if (!last) left <= left - 1'b1;
    end
  end

  AST_LEFT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && last) |=> last); // R1
endmodule

// File: rtl/ctl_resp.sv
module ctl_resp
  import ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel,
  input  logic      w_vld,
  input  logic      ld_rd,
  input  logic      ld_echo,
  input  ctl_word_t rd_data,
  input  logic      rd_hit,
  input  ctl_word_t w_data,
  output ctl_word_t tx_word
);
  function automatic ctl_word_t mask_rd(input ctl_word_t d, input logic hit);
    return hit ? d : '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tx_word <= '0;
    else if (!sel)   tx_word <= '0;
    else if (w_vld) begin
      if (ld_rd)        tx_word <= mask_rd(rd_data, rd_hit);
      else if (ld_echo) tx_word <= w_data;
      else              tx_word <= '0;
    end
  end

  AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rd && !rd_hit) |=> (tx_word == '0)); // R4
endmodule

// File: rtl/spi_ctl_target.sv
module spi_ctl_target
  import ctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              w_vld,
  input  logic [31:0]       w_data,
  output logic [31:0]       miso_word,
  output logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_rdata,
  input  logic              reg_hit,
  output logic              reg_we,
  output logic [31:0]       reg_wdata
);
  localparam int WR_BIT = WORD_W - 1;

  function automatic logic f_is_write(input ctl_word_t w);
    return w[WR_BIT];
  endfunction

  function automatic logic [ADDR_W-1:0] f_hdr_addr(input ctl_word_t w);
    return w[CNT_W +: ADDR_W];
  endfunction

  function automatic logic [CNT_W-1:0] f_hdr_cnt(input ctl_word_t w);
    return w[CNT_W-1:0];
  endfunction

  // Read answers the start address at header time, so its counter begins one ahead.
  function automatic logic [ADDR_W-1:0] f_first(input logic [ADDR_W-1:0] a, input logic wr);
    return wr ? a : a + 1'b1;
  endfunction

  ctl_state_e        state;
  logic              ev_hdr, ev_rd, ev_wr, ev_trail;
  logic              last;
  logic [ADDR_W-1:0] cur_addr;
  logic              hdr_wr;
  logic              step;
  logic              ld_rd, ld_echo;

  assign hdr_wr  = f_is_write(w_data);
  assign step    = (ev_rd && !last) || ev_wr;
  assign ld_rd   = (ev_hdr && !hdr_wr) || (ev_rd && !last);
  assign ld_echo = (ev_hdr && hdr_wr) || ev_wr;

  ctl_seq u_seq (
    .clk(clk), .rst_n(rst_n), .sel(sel), .w_vld(w_vld),
    .hdr_wr(hdr_wr), .last(last), .state(state),
    .ev_hdr(ev_hdr), .ev_rd(ev_rd), .ev_wr(ev_wr), .ev_trail(ev_trail)
  );

  ctl_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(ev_hdr),
    .load_addr(f_first(f_hdr_addr(w_data), hdr_wr)),
    .load_cnt(f_hdr_cnt(w_data)), .step(step),
    .cur_addr(cur_addr), .last(last)
  );

  ctl_resp u_resp (
    .clk(clk), .rst_n(rst_n), .sel(sel), .w_vld(w_vld),
    .ld_rd(ld_rd), .ld_echo(ld_echo), .rd_data(reg_rdata),
    .rd_hit(reg_hit), .w_data(w_data), .tx_word(miso_word)
  );

  assign reg_addr  = (state == ST_HDR) ? f_hdr_addr(w_data) : cur_addr;
  assign reg_we    = ev_wr & reg_hit;
  assign reg_wdata = w_data;

  AST_RD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD) |-> !reg_we); // R3
  AST_UNIMPL_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_hit |-> !reg_we); // R8
  AST_TRAIL_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRAIL) |-> !reg_we); // R7
  AST_ECHO_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |=> (miso_word == $past(w_data))); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE && w_vld) |=> (miso_word == '0)); // R10
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (miso_word == '0)); // R9
endmodule

// File: tb/test_spi_ctl_target.sv
`timescale 1ns/1ps
module test_spi_ctl_target;
  localparam int AW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 1'b0;
  logic          w_vld = 1'b0;
  logic [31:0]   w_data = '0;
  logic [31:0]   miso_word;
  logic [AW-1:0] reg_addr;
  logic [31:0]   reg_rdata;
  logic          reg_hit;
  logic          reg_we;
  logic [31:0]   reg_wdata;

  logic [31:0] mem [256];
  logic [31:0] expm [256];
  int  n_chk = 0, n_bad = 0;
  bit  in_read = 0;
  int  rd_we_cnt = 0, unimpl_we_cnt = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  spi_ctl_target #(.ADDR_W(AW), .CNT_W(CW)) i_spi_ctl_target (
    .clk(clk), .rst_n(rst_n), .sel(sel), .w_vld(w_vld), .w_data(w_data),
    .miso_word(miso_word), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .reg_hit(reg_hit), .reg_we(reg_we), .reg_wdata(reg_wdata)
  );

  function automatic bit impl(input logic [AW-1:0] a);
    return (a < 16) && (a != 5);
  endfunction

  function automatic logic [31:0] mk_hdr(input bit wr, input logic [AW-1:0] a, input int n);
    logic [31:0] h;
    h = '0;
    h[31] = wr;
    h[CW +: AW] = a;
    h[CW-1:0] = CW'(n - 1);
    return h;
  endfunction

  assign reg_rdata = mem[reg_addr];
  assign reg_hit   = impl(reg_addr);

  always @(posedge clk) begin
    if (reg_we) mem[reg_addr] <= reg_wdata;
    if (rst_n && reg_we && in_read) rd_we_cnt++;
    if (rst_n && reg_we && !impl(reg_addr)) unimpl_we_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    r = miso_word;
    sel = 1'b1; w_vld = 1'b1; w_data = d;
    @(negedge clk);
    w_vld = 1'b0;
  endtask

  task automatic drop_sel();
    @(negedge clk); sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input int n, input int seed);
    logic [31:0] h, r, prev;
    logic [AW-1:0] ta;
    h = mk_hdr(1'b1, a, n);
    xfer(h, r);
    prev = h;
    for (int k = 0; k < n; k++) begin
      logic [31:0] d;
      d = 32'hA500_0000 ^ (32'(seed) << 16) ^ (32'(a) << 8) ^ 32'(k);
      xfer(d, r);
      chk(r == prev, "R6 echo", r, prev);
      if (impl(AW'(a + k))) expm[AW'(a + k)] = d;
      prev = d;
    end
    xfer(32'hDEAD_BEEF, r);
    chk(r == prev, "R6 trailing echo", r, prev);
    xfer(32'h1234_5678, r);
    chk(r == 0, "R10 done quiet", r, 0);
    drop_sel();
    for (int k = 0; k <= n; k++) begin
      ta = AW'(a + k);
      chk(mem[ta] == expm[ta], (k == n) ? "R7 trailing ignored" : "R5 R8 commit", mem[ta], expm[ta]);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int n);
    logic [31:0] r, e;
    logic [AW-1:0] ta;
    xfer(mk_hdr(1'b0, a, n), r);
    in_read = 1;
    for (int k = 0; k < n; k++) begin
      ta = AW'(a + k);
      xfer(32'hFFFF_FFFF ^ 32'(k), r);
      e = impl(ta) ? expm[ta] : 32'h0;
      chk(r == e, impl(ta) ? "R2 read data" : "R4 unimpl zero", r, e);
    end
    xfer(32'h8000_0000, r);
    chk(r == 0, "R10 after read", r, 0);
    in_read = 0;
    drop_sel();
  endtask

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 32'h0101_0101 * 32'(i) + 32'h77;
      expm[i] = 32'h0101_0101 * 32'(i) + 32'h77;
    end
    repeat (3) @(negedge clk);
    chk(miso_word == 0, "R11 reset miso", miso_word, 0);
    chk(reg_we == 0, "R11 reset we", 32'(reg_we), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(miso_word == 0, "R11 after reset", miso_word, 0);

    // R1 R5 R2: sweep starts and lengths
    for (int a = 0; a < 20; a++)
      for (int n = 1; n <= 4; n++) begin
        do_write(AW'(a), n, a * 4 + n);
        do_read(AW'(a), n);
      end

    // R2 R5: address wrap modulo 2^AW, full count field
    do_write(8'hFE, 4, 99);
    do_read(8'hFE, 4);
    do_read(8'h00, 16);

    // R9: abort part way through a write
    xfer(mk_hdr(1'b1, 8'd8, 3), r);
    xfer(32'hCAFE_0008, r);
    expm[8] = 32'hCAFE_0008;
    drop_sel();
    xfer(mk_hdr(1'b0, 8'd8, 3), r);
    chk(r == 0, "R9 abort clears miso", r, 0);
    for (int k = 0; k < 3; k++) begin
      xfer(32'h0, r);
      chk(r == expm[8 + k], "R9 abort commits only sent words", r, expm[8 + k]);
    end
    drop_sel();

    chk(rd_we_cnt == 0, "R3 no write in read", 32'(rd_we_cnt), 0);
    chk(unimpl_we_cnt == 0, "R8 no unimpl write", 32'(unimpl_we_cnt), 0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule